// File: doc/BRIEF.md
# Packed Quantized Dot-Product Engine

The engine computes dot products of quantized neural-network tensors one 32-bit word pair at a time. An activation word and a weight word arrive together on a valid/ready input. Each word holds several signed sub-word elements. A precision code, taken at the start of each accumulation, sets the element width. The engine splits the pair into elements, multiplies matching elements, and adds each product to a 32-bit signed running sum as soon as that element is taken out.

A binary mode is also provided. In this mode every bit is a ±1 value and a whole word pair contributes a single XNOR/population-count term, so no multiplier is used. In the multi-bit modes, any element pair in which either operand is zero is detected when the word is accepted. Such pairs are never sequenced, which shortens the time the engine stays busy.

Software-side use is simple. Pulse the clear input, then stream the word pairs and mark the final pair with the last flag. Read the sum when the done pulse appears.

Top module: `qdot_engine`

## Requirements
- R1: After reset, `acc_o` is 0, `done_o` is 0 and `in_ready_o` is 1.
- R2: The `mode_i` codes 0, 1, 2 and 3 select 16-, 8-, 4- and 2-bit elements, giving 2, 4, 8 and 16 elements per word. Element k occupies bits [k*W+W-1 : k*W] and is a two's-complement value. A word pair adds the sum over k of act_k*wgt_k to the accumulator.
- R3: The `mode_i` codes 4 to 7 select binary mode. A word pair then adds 2*P-32 to the accumulator, where P is the number of bit positions at which the two words are equal.
- R4: `mode_i` is sampled only on the first word accepted after reset or after a clear. Later words use that sampled mode whatever `mode_i` holds.
- R5: In a multi-bit mode, an accepted word keeps the engine busy (`in_ready_o` low) for N cycles, where N is the number of element pairs with both operands nonzero. When N is 0 the word takes 1 cycle and leaves the sum unchanged. A binary word takes 1 cycle.
- R6: `in_ready_o` is 1 only when the engine is idle and `clear_i` is low. A word offered while `clear_i` is high is not taken.
- R7: When `clear_i` is high at a clock edge, `acc_o` is 0 after that edge. The same edge abandons any word in progress, cancels any pending done pulse, and re-arms mode sampling.
- R8: For a word accepted with `last_i`=1, `acc_o` holds the final sum from the edge at which its last element is added. `done_o` is high for exactly one cycle, starting one clock after that edge.
- R9: The accumulator wraps modulo 2^32.
- R10: While the engine is idle, with no word accepted and `clear_i` low, `acc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Precision code (0:16b, 1:8b, 2:4b, 3:2b, 4-7:binary) |
| clear_i | input | 1 | Synchronous clear of the sum and the sequence |
| in_valid_i | input | 1 | Word pair offered |
| in_ready_o | output | 1 | Engine can accept a word pair |
| act_i | input | 32 | Packed activation word |
| wgt_i | input | 32 | Packed weight word |
| last_i | input | 1 | Marks the final word pair of the dot product |
| acc_o | output | 32 | Signed running sum |
| done_o | output | 1 | One-cycle pulse after the final sum is formed |

## Verification
The bench builds the engine with its default parameters: 32-bit words, 16-bit lanes and a 32-bit accumulator. With these values, two words of 16-bit extreme values are enough to drive the sum past the 32-bit range and exercise the wrap. A full 2-bit word also reaches the deepest pending mask, which gives the longest sixteen-cycle busy stretch. A behavioural model uses queues of per-element products to predict ready, sum and done in every cycle. Directed cases cover zero-skip cycle counts, clear in the middle of a word, and mode sampling.

// File: rtl/qdot_pkg.sv
package qdot_pkg;

  localparam int NUM_PREC = 4;   // multi-bit precisions: 16, 8, 4, 2 bits
  localparam int BASE_FW  = 16;  // widest field width

  typedef enum logic [2:0] {
    QM_W16 = 3'd0,
    QM_W8  = 3'd1,
    QM_W4  = 3'd2,
    QM_W2  = 3'd3,
    QM_BIN = 3'd4
  } qmode_e;

  // Fold every code with the top bit set onto the binary mode.
  function automatic logic [2:0] norm_mode(input logic [2:0] code);
    return code[2] ? QM_BIN : code;
  endfunction

endpackage

// File: rtl/qdot_livemask.sv
// Flags the element pairs whose operands are both nonzero, for each
// multi-bit precision, then selects the requested one.
module qdot_livemask
  import qdot_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int MAX_EL = WORD_W / 2
) (
  input  logic [WORD_W-1:0] act,
  input  logic [WORD_W-1:0] wgt,
  input  logic [1:0]        sel,
  output logic [MAX_EL-1:0] live
);

  logic [MAX_EL-1:0] cand [NUM_PREC];

  for (genvar g = 0; g < NUM_PREC; g++) begin : g_prec
    localparam int FW  = BASE_FW >> g;
    localparam int NEL = WORD_W / FW;
    logic [MAX_EL-1:0] m;

    always_comb begin
      m = '0;
      for (int e = 0; e < NEL; e++) begin
        m[e] = (|act[e*FW +: FW]) & (|wgt[e*FW +: FW]);
      end
    end

    assign cand[g] = m;
  end

  assign live = cand[sel];

endmodule

// File: rtl/qdot_unpack.sv
// Extracts one element by shift and mask and sign-extends it to a lane.
module qdot_unpack
  import qdot_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [WORD_W-1:0]        word,
  input  logic [1:0]               sel,
  input  logic [IDX_W-1:0]         idx,
  output logic signed [LANE_W-1:0] lane
);

  logic signed [LANE_W-1:0] cand [NUM_PREC];

  for (genvar g = 0; g < NUM_PREC; g++) begin : g_prec
    localparam int FW = BASE_FW >> g;
    logic signed [FW-1:0] field;

    assign field   = FW'(word >> (int'(idx) * FW));
    assign cand[g] = LANE_W'(field);
  end

  assign lane = cand[sel];

endmodule

// File: rtl/qdot_popcnt.sv
// Binary-mode term: matching bits count +1, differing bits count -1.
module qdot_popcnt #(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 32
) (
  input  logic [WORD_W-1:0] act,
  input  logic [WORD_W-1:0] wgt,
  output logic [ACC_W-1:0]  term
);

  logic [WORD_W-1:0] agree;
  int                ones;

  assign agree = ~(act ^ wgt);

  always_comb begin
    ones = 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (agree[i]) ones++;
    end
    term = ACC_W'(2 * ones - WORD_W);
  end

endmodule

// File: rtl/qdot_pick.sv
// Lowest-index set bit of the pending mask.
module qdot_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/qdot_engine.sv
module qdot_engine
  import qdot_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              clear_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] act_i,
  input  logic [WORD_W-1:0] wgt_i,
  input  logic              last_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              done_o
);

  localparam int MAX_EL = WORD_W / 2;
  localparam int IDX_W  = $clog2(MAX_EL);
  localparam int PROD_W = 2 * LANE_W;

  // control state
  logic              busy_q,  busy_d;
  logic              first_q, first_d;
  logic              dpend_q, dpend_d;
  logic              done_q,  done_d;
  logic [MAX_EL-1:0] pend_q,  pend_d;
  logic [ACC_W-1:0]  acc_q,   acc_d;

  // word registers (load-enabled, no reset)
  logic [WORD_W-1:0] act_q, wgt_q;
  logic              last_q;
  logic [2:0]        mode_q;

  logic              take, ld_word;
  logic [2:0]        eff_mode;
  logic              eff_bin, cur_bin;
  logic [MAX_EL-1:0] live_in, pend_clr;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic signed [LANE_W-1:0] a_lane, w_lane;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  bin_term, step_add;
  logic              finish;

  assign in_ready_o = ~busy_q & ~clear_i;
  assign take       = in_valid_i & in_ready_o;
  assign ld_word    = take;

  assign eff_mode = first_q ? norm_mode(mode_i) : mode_q;
  assign eff_bin  = (eff_mode == QM_BIN);
  assign cur_bin  = (mode_q == QM_BIN);

  qdot_livemask #(.WORD_W(WORD_W), .MAX_EL(MAX_EL)) u_live (
    .act  (act_i),
    .wgt  (wgt_i),
    .sel  (eff_mode[1:0]),
    .live (live_in)
  );

  qdot_pick #(.N(MAX_EL), .IDX_W(IDX_W)) u_pick (
    .req (pend_q),
    .idx (pick_idx)
  );

  qdot_unpack #(.WORD_W(WORD_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_unpack_a (
    .word (act_q),
    .sel  (mode_q[1:0]),
    .idx  (pick_idx),
    .lane (a_lane)
  );

  qdot_unpack #(.WORD_W(WORD_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_unpack_w (
    .word (wgt_q),
    .sel  (mode_q[1:0]),
    .idx  (pick_idx),
    .lane (w_lane)
  );

  qdot_popcnt #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_pop (
    .act  (act_q),
    .wgt  (wgt_q),
    .term (bin_term)
  );

  assign pick_any = |pend_q;
  assign prod     = a_lane * w_lane;
  assign pend_clr = pend_q & ~(MAX_EL'(1) << pick_idx);

  always_comb begin
    if (cur_bin)       step_add = bin_term;
    else if (pick_any) step_add = ACC_W'(prod);
    else               step_add = '0;
  end

  assign finish = busy_q & (cur_bin | (pend_clr == '0));

  // next-state logic
  always_comb begin
    busy_d  = busy_q;
    first_d = first_q;
    dpend_d = dpend_q;
    done_d  = done_q;
    pend_d  = pend_q;
    acc_d   = acc_q;
    if (clear_i) begin
      busy_d  = 1'b0;
      first_d = 1'b1;
      dpend_d = 1'b0;
      done_d  = 1'b0;
      pend_d  = '0;
      acc_d   = '0;
    end else begin
      done_d  = dpend_q;
      dpend_d = finish & last_q;
      if (busy_q) begin
        acc_d  = acc_q + step_add;
        pend_d = pend_clr;
        if (finish) busy_d = 1'b0;
      end else if (take) begin
        busy_d  = 1'b1;
        first_d = 1'b0;
        pend_d  = eff_bin ? '0 : live_in;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b1;
      dpend_q <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      acc_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      first_q <= first_d;
      dpend_q <= dpend_d;
      done_q  <= done_d;
      pend_q  <= pend_d;
      acc_q   <= acc_d;
    end
  end

  // word registers
  always_ff @(posedge clk) begin
    if (ld_word) begin
      act_q  <= act_i;
      wgt_q  <= wgt_i;
      last_q <= last_i;
      mode_q <= eff_mode;
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;

endmodule

// File: rtl/qdot_engine_chk.sv
module qdot_engine_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [ACC_W-1:0] acc_o,
  input logic             done_o
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R8

  AST_DONE_SUM_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $stable(acc_o));  // R8

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_o == '0 && !done_o));  // R7

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> !in_ready_o);  // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready_o && !in_valid_i) |=> $stable(acc_o));  // R10

endmodule

bind qdot_engine qdot_engine_chk #(.ACC_W(ACC_W)) chk_i (.*);

// File: tb/qdot_engine_tb_top.sv
`timescale 1ns/1ps
module qdot_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        clear_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] act_i = '0;
  logic [31:0] wgt_i = '0;
  logic        last_i = 1'b0;
  logic [31:0] acc_o;
  logic        done_o;

  always #2 clk = ~clk;  // 250 MHz

  qdot_engine dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clear_i(clear_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .act_i(act_i),
    .wgt_i(wgt_i), .last_i(last_i), .acc_o(acc_o), .done_o(done_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  bit          m_busy, m_done, m_dpend, m_first, m_last;
  int          m_mode;
  logic [31:0] m_acc;
  int          q[$];

  function automatic int elem(input logic [31:0] wd, input int w, input int i);
    int v;
    v = int'((wd >> (i * w)) & ((32'd1 << w) - 32'd1));
    if (v >= (1 << (w - 1))) v -= (1 << w);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dpend = 0; m_first = 1; m_last = 0;
      m_mode = 1; m_acc = '0; q.delete();
    end else if (clear_i) begin
      m_busy = 0; m_done = 0; m_dpend = 0; m_first = 1;
      m_acc = '0; q.delete();
    end else begin
      m_done = m_dpend;
      m_dpend = 0;
      if (m_busy) begin
        m_acc = m_acc + 32'(q.pop_front());
        if (q.size() == 0) begin
          m_busy = 0;
          if (m_last) m_dpend = 1;
        end
      end else if (in_valid_i) begin
        if (m_first) m_mode = (int'(mode_i) >= 4) ? 4 : int'(mode_i);
        m_first = 0;
        m_last = last_i;
        if (m_mode == 4) begin
          q.push_back(2 * $countones(~(act_i ^ wgt_i)) - 32);
        end else begin
          for (int i = 0; i < 32 / (16 >> m_mode); i++) begin
            int a, b;
            a = elem(act_i, 16 >> m_mode, i);
            b = elem(wgt_i, 16 >> m_mode, i);
            if (a != 0 && b != 0) q.push_back(a * b);
          end
          if (q.size() == 0) q.push_back(0);
        end
        m_busy = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit exp_rdy;
    #1;
    exp_rdy = !m_busy && !clear_i;
    n_chk++;
    if (in_ready_o !== exp_rdy || acc_o !== m_acc || done_o !== m_done) begin
      n_fail++;
      $display("FAIL %s cycle: ready=%b acc=%h done=%b expected ready=%b acc=%h done=%b",
               cur_req, in_ready_o, acc_o, done_o, exp_rdy, m_acc, m_done);
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [31:0] a, input logic [31:0] w,
                      input bit l);
    @(negedge clk);
    mode_i = m; act_i = a; wgt_i = w; last_i = l; in_valid_i = 1'b1;
    #1;
    while (!in_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    #1;
    while (!in_ready_o) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    int cyc;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ready", {31'b0, in_ready_o}, 32'd1);
    check("R1 acc", acc_o, 32'd0);
    check("R1 done", {31'b0, done_o}, 32'd0);

    // R2: 8-bit elements, LSB first, signed
    cur_req = "R2";
    send(3'd1, 32'h7F80_03FD, 32'h0205_FFFE, 1'b1);
    wait_idle(cyc);
    check("R2 8-bit sum", acc_o, 32'hFFFF_FE81);  // -383
    do_clear();
    send(3'd0, 32'h8000_0005, 32'h0002_FFFD, 1'b1);
    wait_idle(cyc);
    check("R2 16-bit sum", acc_o, 32'hFFFE_FFF1);  // -65551
    do_clear();
    send(3'd2, 32'h0000_00F7, 32'h0000_0032, 1'b1);
    wait_idle(cyc);
    check("R2 4-bit sum", acc_o, 32'd11);
    do_clear();
    send(3'd3, 32'hFFFF_FFFF, 32'h5555_5555, 1'b1);
    wait_idle(cyc);
    check("R2 2-bit sum", acc_o, 32'hFFFF_FFF0);  // -16
    check("R5 full 2-bit word cycles", 32'(cyc), 32'd16);

    // R3: binary mode
    cur_req = "R3";
    do_clear();
    send(3'd4, 32'hA5A5_1234, 32'hA5A5_1234, 1'b0);
    wait_idle(cyc);
    check("R5 binary word cycles", 32'(cyc), 32'd1);
    send(3'd4, 32'h0000_000F, 32'h0000_0000, 1'b1);
    wait_idle(cyc);
    check("R3 binary sum", acc_o, 32'd56);
    do_clear();
    send(3'd7, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    wait_idle(cyc);
    check("R3 code 7 binary", acc_o, 32'hFFFF_FFE0);  // -32

    // R4: mode held after first word
    cur_req = "R4";
    do_clear();
    send(3'd1, 32'h0000_0102, 32'h0000_0304, 1'b0);
    wait_idle(cyc);
    send(3'd0, 32'h0000_0102, 32'h0000_0304, 1'b1);
    wait_idle(cyc);
    check("R4 mode ignored", acc_o, 32'd22);

    // R5: zero-skip cycle counts
    cur_req = "R5";
    do_clear();
    send(3'd3, 32'hFFFF_FFFF, 32'h0000_0005, 1'b1);
    wait_idle(cyc);
    check("R5 two live pairs cycles", 32'(cyc), 32'd2);
    check("R5 two live pairs sum", acc_o, 32'hFFFF_FFFE);
    do_clear();
    send(3'd2, 32'h0000_0000, 32'h1234_5678, 1'b1);
    wait_idle(cyc);
    check("R5 all-zero word cycles", 32'(cyc), 32'd1);
    check("R5 all-zero word sum", acc_o, 32'd0);
    do_clear();
    send(3'd1, 32'h0101_0101, 32'h0101_0101, 1'b1);
    wait_idle(cyc);
    check("R5 four live pairs cycles", 32'(cyc), 32'd4);

    // R6: no acceptance while clear is high
    cur_req = "R6";
    @(negedge clk);
    clear_i = 1'b1; in_valid_i = 1'b1; mode_i = 3'd1;
    act_i = 32'h0000_0007; wgt_i = 32'h0000_0007; last_i = 1'b1;
    #1;
    check("R6 ready low under clear", {31'b0, in_ready_o}, 32'd0);
    @(negedge clk);
    clear_i = 1'b0; in_valid_i = 1'b0;
    #1;
    check("R6 word not taken", {31'b0, in_ready_o}, 32'd1);
    check("R6 sum untouched", acc_o, 32'd0);

    // R8: done timing on a one-element word
    cur_req = "R8";
    send(3'd1, 32'h0000_0002, 32'h0000_0003, 1'b1);
    #1;
    check("R8 busy after accept", {31'b0, in_ready_o}, 32'd0);
    @(negedge clk); #1;
    check("R8 sum formed", acc_o, 32'd6);
    check("R8 done not yet", {31'b0, done_o}, 32'd0);
    @(negedge clk); #1;
    check("R8 done high", {31'b0, done_o}, 32'd1);
    @(negedge clk); #1;
    check("R8 done one cycle", {31'b0, done_o}, 32'd0);

    // R7: clear in the middle of a word, then mode re-sampled
    cur_req = "R7";
    do_clear();
    send(3'd3, 32'hFFFF_FFFF, 32'h5555_5555, 1'b1);
    repeat (3) @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    #1;
    check("R7 sum cleared", acc_o, 32'd0);
    check("R7 idle after clear", {31'b0, in_ready_o}, 32'd1);
    repeat (20) @(negedge clk);
    check("R7 no stale done", {31'b0, done_o}, 32'd0);
    check("R7 sum stays zero", acc_o, 32'd0);
    send(3'd0, 32'h0000_0102, 32'h0000_0304, 1'b1);
    wait_idle(cyc);
    check("R7 mode re-sampled", acc_o, 32'd199176);

    // R9: wrap
    cur_req = "R9";
    do_clear();
    send(3'd0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b0);
    wait_idle(cyc);
    send(3'd0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b1);
    wait_idle(cyc);
    check("R9 wrapped sum", acc_o, 32'hFFFC_0004);

    // R10: idle hold
    cur_req = "R10";
    held = acc_o;
    repeat (6) @(negedge clk);
    #1;
    check("R10 idle hold", acc_o, held);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule